// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Reads

This block is a synthesizable behavioural model of a single-clock synchronous SRAM. The data word is split into byte lanes of nine bits each. Every synchronous control and data input is captured on the rising clock edge. Read data leaves the array through a flow-through path, so the word at a newly registered address appears on the output in the cycle that follows that edge, with no output register in between.

An access begins when one of two address strobes is asserted. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write controls. After the start, a two-bit burst counter forms the low address bits. The counter moves only while the advance input is low. An asynchronous order-select input chooses between linear order and interleaved order.

Three chip-select inputs qualify every start. Writes are masked per lane by a shared lane gate, and a global-write input overrides the mask. An asynchronous output-enable input and a sleep input remove the read data from the outputs. Sleep also freezes the block. High impedance is modelled by a valid flag, with zero data whenever the flag is low.

Top module: `burst_sram`

## Requirements
- R1: After synchronous reset no burst is active and `rdata_en` is 0.
- R2: A controller-strobe start (`ctl_strobe_n`=0, all selects active, no processor start) is a write when any lane is enabled. Lane k covers `wdata[9k+8:9k]` and is written at that edge to the presented address when `byte_gate_n`=0 and `lane_wr_n[k]`=0. With `byte_gate_n`=1 and `all_wr_n`=1 nothing is written, and the start is a read.
- R3: `all_wr_n`=0 writes all lanes, whatever the values of `byte_gate_n` and `lane_wr_n`.
- R4: A processor-strobe start (`cpu_strobe_n`=0 with all selects active) is always a read. The write controls are ignored, and it takes priority over a controller strobe presented at the same edge.
- R5: Flow-through: the word at the address registered at an edge is on `rdata` in the cycle after that edge, with `rdata_en`=1 if output is enabled.
- R6: After a start, the burst counter advances at an edge only when `step_n`=0. Otherwise the address holds. Address bits above bit 1 stay fixed for the whole burst.
- R7: With `order_lin`=1, the low two address bits are (start low bits + count) mod 4.
- R8: With `order_lin`=0, the low two address bits are the start low bits XOR the count.
- R9: A start needs `sel_n`=0, `sel_hi`=1 and `sel2_n`=0. A controller strobe, or a processor strobe with `sel_n`=0, presented while any select is inactive ends the burst (`rdata_en`=0). A processor strobe with `sel_n`=1 is ignored, and the burst goes on.
- R10: `rdata_en` is 0, and `rdata` is 0, while `oe_n`=1 or during any cycle that follows a write edge.
- R11: While `sleep`=1, `rdata_en` is 0. Edges cause no write and no change of burst state, and memory contents are kept.
- R12: During an active burst with no strobe, write intent at an edge writes the masked lanes at the burst address formed after that edge's advance. A cycle without write intent reads that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address, loaded on a start |
| wdata | input | LANES*LANE_W | Write data, lane k at bits 9k+8..9k |
| sel_n | input | 1 | Chip select, active low |
| sel_hi | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, read-only start, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, read or write start, active low |
| step_n | input | 1 | Burst advance, active low |
| byte_gate_n | input | 1 | Gate for per-lane enables, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| order_lin | input | 1 | Asynchronous burst order: 1 linear, 0 interleaved |
| sleep | input | 1 | Asynchronous sleep, active high |
| rdata | output | LANES*LANE_W | Flow-through read data, zero when not valid |
| rdata_en | output | 1 | Output-drive flag (0 models high impedance) |

## Verification
The bench uses the defaults ADDR_W=6, LANES=4 and LANE_W=9: 64 words of 36 bits. At this size the reference array mirrors the whole memory, and bursts that start near the top of a four-word group show wrap-around with the upper address bits held. Four lanes make single-lane and alternating-lane masks visible in the read-back of one word. Every cycle's output is scored against a reference model, covering both burst orders, strobe priority, deselect, output enable and sleep.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int CNT_W = 2;

    typedef enum logic [2:0] {
        ACT_IDLE  = 3'd0,
        ACT_LOAD  = 3'd1,
        ACT_DESEL = 3'd2,
        ACT_STEP  = 3'd3,
        ACT_STAY  = 3'd4
    } act_e;

    typedef struct packed {
        act_e act;
        logic wr;
    } cmd_t;

    function automatic logic [CNT_W-1:0] seq_low(
        input logic [CNT_W-1:0] start_low,
        input logic [CNT_W-1:0] count,
        input logic             linear
    );
        logic [CNT_W-1:0] sum;
        sum = start_low + count;
        return linear ? sum : (start_low ^ count);
    endfunction

endpackage

// File: rtl/burst_access_ctrl.sv
module burst_access_ctrl
    import burst_sram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             step_n,
    input  logic             sel_n,
    input  logic             sel_hi,
    input  logic             sel2_n,
    input  logic             byte_gate_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             all_wr_n,
    input  logic             sleep,
    input  logic             active_q,
    output cmd_t             cmd,
    output logic [LANES-1:0] lane_we
);

    logic             chips_on;
    logic [LANES-1:0] mask;
    logic             wr_intent;

    assign chips_on  = !sel_n && sel_hi && !sel2_n;
    assign wr_intent = |mask;

    always_comb begin
        if (!all_wr_n)
            mask = '1;
        else if (!byte_gate_n)
            mask = ~lane_wr_n;
        else
            mask = '0;
    end

    always_comb begin
        cmd.act = ACT_IDLE;
        cmd.wr  = 1'b0;
        if (sleep) begin
            cmd.act = ACT_IDLE;
        end else if (!cpu_strobe_n && !sel_n) begin
            cmd.act = chips_on ? ACT_LOAD : ACT_DESEL;
        end else if (!ctl_strobe_n) begin
            cmd.act = chips_on ? ACT_LOAD : ACT_DESEL;
            cmd.wr  = chips_on && wr_intent;
        end else if (active_q) begin
            cmd.act = step_n ? ACT_STAY : ACT_STEP;
            cmd.wr  = wr_intent;
        end
    end

    assign lane_we = cmd.wr ? mask : '0;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              order_lin,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic              active_q,
    output logic              rd_q
);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;

    assign cnt_nxt  = (cmd.act == ACT_STEP) ? cnt_q + 1'b1 : cnt_q;
    assign cur_addr = {base_q[ADDR_W-1:CNT_W], seq_low(base_q[CNT_W-1:0], cnt_q, order_lin)};
    assign tgt_addr = (cmd.act == ACT_LOAD) ? ext_addr
                    : {base_q[ADDR_W-1:CNT_W], seq_low(base_q[CNT_W-1:0], cnt_nxt, order_lin)};

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
            rd_q     <= 1'b0;
        end else begin
            unique case (cmd.act)
                ACT_LOAD: begin
                    base_q   <= ext_addr;
                    cnt_q    <= '0;
                    active_q <= 1'b1;
                    rd_q     <= !cmd.wr;
                end
                ACT_DESEL: begin
                    active_q <= 1'b0;
                    rd_q     <= 1'b0;
                end
                ACT_STEP: begin
                    cnt_q <= cnt_nxt;
                    rd_q  <= !cmd.wr;
                end
                ACT_STAY: begin
                    rd_q <= !cmd.wr;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g])
                store[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = store[raddr];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    sel_n,
    input  logic                    sel_hi,
    input  logic                    sel2_n,
    input  logic                    cpu_strobe_n,
    input  logic                    ctl_strobe_n,
    input  logic                    step_n,
    input  logic                    byte_gate_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    all_wr_n,
    input  logic                    oe_n,
    input  logic                    order_lin,
    input  logic                    sleep,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_en
);

    localparam int DATA_W = LANES * LANE_W;

    cmd_t              cmd;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] tgt_addr;
    logic              active_q;
    logic              rd_q;
    logic [DATA_W-1:0] core_rdata;

    burst_access_ctrl #(.LANES(LANES)) u_ctrl (
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .step_n       (step_n),
        .sel_n        (sel_n),
        .sel_hi       (sel_hi),
        .sel2_n       (sel2_n),
        .byte_gate_n  (byte_gate_n),
        .lane_wr_n    (lane_wr_n),
        .all_wr_n     (all_wr_n),
        .sleep        (sleep),
        .active_q     (active_q),
        .cmd          (cmd),
        .lane_we      (lane_we)
    );

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .ext_addr  (addr),
        .order_lin (order_lin),
        .cur_addr  (cur_addr),
        .tgt_addr  (tgt_addr),
        .active_q  (active_q),
        .rd_q      (rd_q)
    );

    burst_sram_core #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_core (
        .clk     (clk),
        .lane_we (lane_we),
        .waddr   (tgt_addr),
        .wdata   (wdata),
        .raddr   (cur_addr),
        .rdata   (core_rdata)
    );

    assign rdata_en = active_q && rd_q && !oe_n && !sleep;
    assign rdata    = rdata_en ? core_rdata : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
    input logic clk,
    input logic rst,
    input logic sel_n,
    input logic sel_hi,
    input logic sel2_n,
    input logic cpu_strobe_n,
    input logic ctl_strobe_n,
    input logic all_wr_n,
    input logic oe_n,
    input logic sleep,
    input logic rdata_en
);

    logic chips_on;
    assign chips_on = !sel_n && sel_hi && !sel2_n;

    // R10
    oe_blocks_output_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !rdata_en);

    // R11
    sleep_blocks_output_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !rdata_en);

    // R4
    cpu_start_reads_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !cpu_strobe_n && chips_on) |=> (rdata_en == (!oe_n && !sleep)));

    // R10
    write_cycle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep && (cpu_strobe_n || sel_n) && !ctl_strobe_n && chips_on && !all_wr_n)
        |=> !rdata_en);

    // R9
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !ctl_strobe_n && !chips_on) |=> !rdata_en);

endmodule

bind burst_sram burst_sram_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sel_n        (sel_n),
    .sel_hi       (sel_hi),
    .sel2_n       (sel2_n),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .all_wr_n     (all_wr_n),
    .oe_n         (oe_n),
    .sleep        (sleep),
    .rdata_en     (rdata_en)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;

    localparam int AW    = 6;
    localparam int NL    = 4;
    localparam int LW    = 9;
    localparam int DW    = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          sel_n, sel_hi, sel2_n;
    logic          cpu_strobe_n, ctl_strobe_n, step_n;
    logic          byte_gate_n, all_wr_n;
    logic [NL-1:0] lane_wr_n;
    logic          oe_n, order_lin, sleep;
    logic [DW-1:0] rdata;
    logic          rdata_en;

    always #10 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n), .step_n(step_n),
        .byte_gate_n(byte_gate_n), .lane_wr_n(lane_wr_n), .all_wr_n(all_wr_n),
        .oe_n(oe_n), .order_lin(order_lin), .sleep(sleep),
        .rdata(rdata), .rdata_en(rdata_en)
    );

    // reference state
    logic [DW-1:0] ref_mem [DEPTH];
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    logic          m_act, m_rd;

    // scoreboard
    logic          q_en   [$];
    logic [DW-1:0] q_data [$];
    string         q_tag  [$];
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 0;

    function automatic logic [AW-1:0] burst_addr();
        logic [1:0] lo;
        lo = order_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic put_ref(input logic [AW-1:0] a, input logic [NL-1:0] m);
        for (int k = 0; k < NL; k++)
            if (m[k]) ref_mem[a][k*LW +: LW] = wdata[k*LW +: LW];
    endtask

    task automatic model_edge();
        logic [NL-1:0] m;
        logic          chips;
        chips = !sel_n && sel_hi && !sel2_n;
        if (!all_wr_n)         m = '1;
        else if (!byte_gate_n) m = ~lane_wr_n;
        else                   m = '0;
        if (sleep) begin
        end else if (!cpu_strobe_n && !sel_n) begin
            if (chips) begin m_base = addr; m_cnt = 0; m_act = 1; m_rd = 1; end
            else begin m_act = 0; m_rd = 0; end
        end else if (!ctl_strobe_n) begin
            if (chips) begin
                m_base = addr; m_cnt = 0; m_act = 1;
                put_ref(addr, m);
                m_rd = (m == 0);
            end else begin m_act = 0; m_rd = 0; end
        end else if (m_act) begin
            if (!step_n) m_cnt = m_cnt + 1'b1;
            put_ref(burst_addr(), m);
            m_rd = (m == 0);
        end
    endtask

    task automatic tick(input string tag);
        logic en;
        model_edge();
        @(posedge clk);
        en = m_act && m_rd && !oe_n && !sleep;
        q_en.push_back(en);
        q_data.push_back(en ? ref_mem[burst_addr()] : '0);
        q_tag.push_back(tag);
        @(negedge clk);
        #1;
    endtask

    task automatic idle();
        cpu_strobe_n = 1; ctl_strobe_n = 1; step_n = 1;
        byte_gate_n = 1; lane_wr_n = '1; all_wr_n = 1;
    endtask

    task automatic ctl_start(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic g_n, input logic [NL-1:0] l_n, input logic a_n,
                             input string tag);
        idle(); ctl_strobe_n = 0; addr = a; wdata = d;
        byte_gate_n = g_n; lane_wr_n = l_n; all_wr_n = a_n;
        tick(tag);
    endtask

    task automatic cpu_start(input logic [AW-1:0] a, input string tag);
        idle(); cpu_strobe_n = 0; addr = a;
        tick(tag);
    endtask

    task automatic burst_step(input logic adv_n, input logic [DW-1:0] d,
                              input logic a_n, input string tag);
        idle(); step_n = adv_n; wdata = d; all_wr_n = a_n;
        tick(tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (q_en.size() != 0) begin
                logic          e_en;
                logic [DW-1:0] e_d;
                string         t;
                e_en = q_en.pop_front();
                e_d  = q_data.pop_front();
                t    = q_tag.pop_front();
                n_chk++;
                if (rdata_en !== e_en || rdata !== e_d) begin
                    n_fail++;
                    $display("FAIL %s: rdata_en=%0b rdata=%h expected rdata_en=%0b rdata=%h",
                             t, rdata_en, rdata, e_en, e_d);
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // watchdog
    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        m_base = '0; m_cnt = '0; m_act = 0; m_rd = 0;
        rst = 1; addr = '0; wdata = '0;
        sel_n = 0; sel_hi = 1; sel2_n = 0;
        oe_n = 0; order_lin = 1; sleep = 0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 0;
        // R1: reset state
        tick("R1 reset idle");
        tick("R1 reset idle");

        // preload 0..63 with all-lane writes (R2/R12) so every word is known
        for (int b = 0; b < DEPTH; b += 4) begin
            ctl_start(AW'(b), DW'(36'h1_0000_0000 + b * 36'h1_0203), 1, '1, 0, "R2 start write");
            for (int s = 1; s < 4; s++)
                burst_step(0, DW'(36'hA_5000_0000 ^ ((b + s) * 36'h0_0107_0301)), 0, "R12 burst write");
        end
        burst_step(1, '0, 1, "R6 hold after write");

        // R5 / R7: linear read starting at 9
        order_lin = 1;
        cpu_start(6'd9, "R5 flow-through");
        burst_step(0, '0, 1, "R7 linear");
        burst_step(0, '0, 1, "R7 linear");
        burst_step(0, '0, 1, "R7 linear wrap");
        burst_step(1, '0, 1, "R6 no advance");
        burst_step(1, '0, 1, "R6 no advance");

        // R8: interleaved read starting at 10
        order_lin = 0;
        cpu_start(6'd10, "R5 flow-through");
        burst_step(0, '0, 1, "R8 interleaved");
        burst_step(0, '0, 1, "R8 interleaved");
        burst_step(0, '0, 1, "R8 interleaved");

        // R6/R7: upper bits fixed near group top
        order_lin = 1;
        cpu_start(6'd23, "R5 flow-through");
        burst_step(0, '0, 1, "R6 upper fixed");
        burst_step(0, '0, 1, "R7 linear wrap");

        // R2: lane mask under gate
        ctl_start(6'd20, 36'hF_FFFF_FFFF, 0, 4'b1010, 1, "R2 lane write");
        cpu_start(6'd20, "R2 lanes 0,2 only");
        ctl_start(6'd21, 36'h0_0000_0000, 1, 4'b0000, 1, "R2 gate high is read");
        cpu_start(6'd21, "R2 gate high no write");

        // R3: global override
        ctl_start(6'd22, 36'h5_5555_5555, 1, '1, 0, "R3 global write");
        cpu_start(6'd22, "R3 global all lanes");

        // R4: processor start ignores write controls, wins over controller strobe
        idle(); cpu_strobe_n = 0; ctl_strobe_n = 0; addr = 6'd23;
        wdata = 36'h0_DEAD_BEEF; all_wr_n = 0; byte_gate_n = 0; lane_wr_n = '0;
        tick("R4 cpu start is read");
        cpu_start(6'd23, "R4 no write happened");

        // R9: chip selects
        sel_hi = 0;
        ctl_start(6'd8, '0, 1, '1, 1, "R9 deselect");
        sel_hi = 1;
        burst_step(1, '0, 1, "R9 stays deselected");
        cpu_start(6'd8, "R5 flow-through");
        idle(); cpu_strobe_n = 0; sel_n = 1; step_n = 0; addr = 6'd40;
        tick("R9 cpu strobe ignored");
        sel_n = 0;
        sel2_n = 1;
        cpu_start(6'd40, "R9 deselect by sel2_n");
        sel2_n = 0;

        // R10: output enable
        cpu_start(6'd9, "R5 flow-through");
        oe_n = 1;
        burst_step(1, '0, 1, "R10 oe high");
        oe_n = 0;
        burst_step(0, '0, 1, "R10 oe restored");
        burst_step(0, 36'h1_2345_6789, 0, "R10 write cycle quiet");
        burst_step(1, '0, 1, "R12 read back");

        // R11: sleep
        cpu_start(6'd30, "R5 flow-through");
        sleep = 1;
        ctl_start(6'd30, 36'h0_BAD0_0BAD, 1, '1, 0, "R11 sleep no output");
        burst_step(0, 36'h0_BAD0_0BAD, 0, "R11 sleep no output");
        sleep = 0;
        burst_step(1, '0, 1, "R11 contents and state kept");

        // R1: reset mid-burst
        cpu_start(6'd5, "R5 flow-through");
        rst = 1;
        @(posedge clk); @(negedge clk); #1;
        rst = 0;
        m_act = 0; m_rd = 0; m_cnt = 0; m_base = '0;
        burst_step(0, '0, 1, "R1 reset ends burst");

        repeat (3) @(negedge clk);
        done = 1;
        finish_run();
    end

endmodule